// File: doc/BRIEF.md
# SPI Master with Register-Mapped FIFOs

This block is a master-only synchronous serial port reached through a simple 32-bit register bus. Software configures the frame length, clock polarity, clock phase and bit rate, pushes words into an 8-entry transmit queue through the data register and pops received words from an 8-entry receive queue through the same address. Each queued word becomes one frame, sent most significant bit first in Motorola-style SPI framing, while a word of the same length is captured from the serial input. An internal loopback path routes the serial output back into the receiver for self-test. Chip select is not driven here; an external general-purpose output frames the transfers.

The bit rate comes from a cascaded prescaler and post-divider. A status word reports queue occupancy and activity. Four interrupt sources (transmit level, receive level, receive timeout, receive overrun) have a mask, a raw view, a masked view and one combined interrupt line. The two sticky sources are cleared selectively through a clear register.

Bus accesses complete in the cycle they are presented and never wait. Back-pressure is handled by dropping, not stalling: a data write into a full transmit queue is discarded, a data read from an empty receive queue returns zero and pops nothing, and a frame that arrives while the receive queue is full is discarded and flagged. Software avoids loss by watching the status word or the level interrupts.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status word reads 0x0B, the raw interrupt word reads 0x08, the serial clock is low and the interrupt line is low.
- R2: Control word 0 (offset 0x00, 16 bits), control word 1 (offset 0x04, 4 bits), prescale (offset 0x10, 8 bits) and interrupt mask (offset 0x14, 4 bits) read back what was written; offsets 0xFE0 to 0xFFC return the identification bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order.
- R3: A write to the data register (offset 0x08) enqueues into an 8-deep transmit queue and is dropped when the queue is full; a read of the data register dequeues the receive queue in arrival order.
- R4: The serial clock half period is (prescale[7:1]) × (1 + RATE) input clocks, where RATE is control 0 bits 15:8; prescale bit 0 is ignored and a prescale below 2 acts as 2.
- R5: A frame carries (control 0 bits 3:0) + 1 bits, most significant first; the received word is right-justified and zero-extended, and transmit bits above the frame length are ignored.
- R6: Control 0 bit 6 sets the idle level of the serial clock; with control 0 bit 7 clear the output bit changes on trailing edges and input is sampled on leading edges, with it set the output changes on leading edges after the first and input is sampled on trailing edges.
- R7: With control 1 bit 0 set, the receiver takes the transmit output and ignores the serial input pin; with it clear, the receiver samples the serial input pin.
- R8: Status (offset 0x0C) bits are busy at 4, receive-not-full at 3, receive-not-empty at 2, transmit-not-full at 1 and transmit-empty at 0.
- R9: Interrupt bits in the mask (0x14), raw (0x18) and masked (0x1C) words are transmit at 3 (transmit queue holds 4 or fewer), receive at 2 (receive queue holds 4 or more), timeout at 1, overrun at 0; masked equals raw AND mask and the interrupt line is the OR of the masked bits.
- R10: A frame completing while the receive queue is full is discarded and sets raw bit 0, which stays set until a write to the clear register (offset 0x20) with bit 0 set.
- R11: When the receive queue is non-empty and sees no enqueue or dequeue for 32 bit periods, raw bit 1 sets and stays set until a write to the clear register with bit 1 set.
- R12: Frames start only while control 1 bit 1 (enable) is set; clearing it lets the frame in flight finish and starts no more; busy is high while a frame shifts or while enabled with a non-empty transmit queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (pops the receive queue at the data offset) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A wrong shift or edge counter shows at once on the data read back through loopback: a dropped or doubled bit moves every later bit of the word, so one frame exposes it. A divider fault changes the spacing of serial clock edges within the first bit of the next frame, and a phase fault moves the first change of the serial output to a different clock edge. Queue pointer or count faults show up as wrong order or wrong count of returned words, and as status or level-interrupt bits that disagree with the number of words written and read, visible on the next status read.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Word indices (byte address bits 11:2) of the register map.
  localparam logic [9:0] IDX_CTRL0  = 10'h000;
  localparam logic [9:0] IDX_CTRL1  = 10'h001;
  localparam logic [9:0] IDX_DATA   = 10'h002;
  localparam logic [9:0] IDX_STATUS = 10'h003;
  localparam logic [9:0] IDX_PRESC  = 10'h004;
  localparam logic [9:0] IDX_IMASK  = 10'h005;
  localparam logic [9:0] IDX_IRAW   = 10'h006;
  localparam logic [9:0] IDX_IMASKD = 10'h007;
  localparam logic [9:0] IDX_ICLR   = 10'h008;

  // Identification window: byte address bits 11:5 all ones.
  localparam logic [6:0] ID_WINDOW = 7'h7F;

  typedef struct packed {
    logic busy;
    logic rx_not_full;
    logic rx_not_empty;
    logic tx_not_full;
    logic tx_empty;
  } status_t;

  typedef struct packed {
    logic tx_lvl;
    logic rx_lvl;
    logic rx_timeout;
    logic rx_overrun;
  } irq_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h22;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic [W-1:0]             data_i,
  input  logic                     pop_i,
  output logic [W-1:0]             data_o,
  output logic [$clog2(DEPTH):0]   count_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLV = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full_o  = (count_o == FULLV);
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R3: a push into a full queue without a pop leaves the level unchanged
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));

endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PS_W   = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [PS_W-1:0]   prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int HW = PS_W - 1;

  logic [HW-1:0]     half_raw, half_eff, pre_cnt;
  logic [RATE_W-1:0] post_cnt;
  logic              pre_wrap;

  // Bit 0 of the prescaler is ignored; zero after halving acts as one.
  assign half_raw = prescale_i[PS_W-1:1];
  assign half_eff = (half_raw == '0) ? HW'(1) : half_raw;
  assign pre_wrap = (pre_cnt == half_eff - 1'b1);
  assign tick_o   = pre_wrap && (post_cnt == rate_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (restart_i) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      post_cnt <= (post_cnt == rate_i) ? '0 : post_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int MAXW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      start_i,
  input  logic [MAXW-1:0]           tx_word_i,
  input  logic [$clog2(MAXW)-1:0]   width_m1_i,
  input  logic                      cpol_i,
  input  logic                      cpha_i,
  input  logic                      loop_i,
  input  logic                      miso_i,
  output logic                      running_o,
  output logic                      sclk_o,
  output logic                      mosi_o,
  output logic                      done_o,
  output logic [MAXW-1:0]           rx_word_o
);
  localparam int CW = $clog2(MAXW);
  localparam int EW = CW + 1;
  localparam logic [CW-1:0] TOPBIT = CW'(MAXW - 1);

  logic [MAXW-1:0] tx_sr, rx_sr, keep;
  logic [EW-1:0]   edge_cnt, last_edge;
  logic [CW-1:0]   wm1_q;
  logic            cpha_q, din, smp, shf;

  assign last_edge = {wm1_q, 1'b1};
  assign mosi_o    = running_o ? tx_sr[MAXW-1] : 1'b0;
  assign din       = loop_i ? mosi_o : miso_i;
  assign smp       = (edge_cnt[0] == cpha_q);
  assign shf       = !smp && !(cpha_q && (edge_cnt == '0));
  assign keep      = ~(({MAXW{1'b1}} << wm1_q) << 1);
  assign rx_word_o = rx_sr & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      sclk_o    <= 1'b0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      edge_cnt  <= '0;
      wm1_q     <= '0;
      cpha_q    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !running_o) begin
        running_o <= 1'b1;
        edge_cnt  <= '0;
        tx_sr     <= tx_word_i << (TOPBIT - width_m1_i);
        rx_sr     <= '0;
        wm1_q     <= width_m1_i;
        cpha_q    <= cpha_i;
        sclk_o    <= cpol_i;
      end else if (running_o && tick_i) begin
        sclk_o   <= ~sclk_o;
        edge_cnt <= edge_cnt + 1'b1;
        if (smp) rx_sr <= {rx_sr[MAXW-2:0], din};
        if (shf) tx_sr <= tx_sr << 1;
        if (edge_cnt == last_edge) begin
          running_o <= 1'b0;
          done_o    <= 1'b1;
        end
      end else if (!running_o) begin
        sclk_o <= cpol_i;
      end
    end
  end

  // R6: settled idle clock sits at the programmed polarity
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !$past(running_o) && $stable(cpol_i)) |-> (sclk_o == cpol_i));

  // R5: the edge index never passes the last edge of the frame
  assert_edge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (edge_cnt <= last_edge));

  // R5: completion only follows an active frame
  assert_done_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(running_o) && !running_o));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FIFO_DEPTH   = 8,
  parameter int FRAME_MAX    = 16,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic        bus_rd_en,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  import spim_pkg::*;

  localparam int CNTW = $clog2(FIFO_DEPTH) + 1;
  localparam int CW   = $clog2(FRAME_MAX);
  localparam logic [CNTW-1:0] LVL_MARK = CNTW'(FIFO_DEPTH / 2);
  localparam int TO_TICKS = 2 * TIMEOUT_BITS;
  localparam int TOW = $clog2(TO_TICKS + 1);
  localparam logic [TOW-1:0] TO_LIMIT = TOW'(TO_TICKS);

  logic [15:0] ctrl0_q;
  logic [3:0]  ctrl1_q;
  logic [7:0]  presc_q;
  logic [3:0]  imask_q;
  logic        ror_q, rto_q;
  logic [TOW-1:0] to_cnt;

  logic        word_ok, id_hit;
  logic        wr_ctrl0, wr_ctrl1, wr_data, wr_presc, wr_imask, wr_iclr, rd_data;
  logic        clr_rto, clr_ror;
  logic        enable, start, tick;

  logic [FRAME_MAX-1:0] tx_head, rx_head, rx_word;
  logic [CNTW-1:0]      tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic rx_push, rx_pop, sh_running, sh_done;

  status_t stat;
  irq_t    raw, mskd;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[31:16];

  // Address decode
  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign id_hit   = word_ok && (bus_addr[11:5] == ID_WINDOW);
  assign wr_ctrl0 = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_CTRL0);
  assign wr_ctrl1 = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_CTRL1);
  assign wr_data  = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_DATA);
  assign wr_presc = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_PRESC);
  assign wr_imask = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_IMASK);
  assign wr_iclr  = bus_wr_en && word_ok && (bus_addr[11:2] == IDX_ICLR);
  assign rd_data  = bus_rd_en && word_ok && (bus_addr[11:2] == IDX_DATA);
  assign clr_rto  = wr_iclr && bus_wdata[1];
  assign clr_ror  = wr_iclr && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      presc_q <= '0;
      imask_q <= '0;
    end else begin
      if (wr_ctrl0) ctrl0_q <= bus_wdata[15:0];
      if (wr_ctrl1) ctrl1_q <= bus_wdata[3:0];
      if (wr_presc) presc_q <= bus_wdata[7:0];
      if (wr_imask) imask_q <= bus_wdata[3:0];
    end
  end

  assign enable = ctrl1_q[1];
  assign start  = enable && !tx_empty && !sh_running;

  spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_i(wr_data), .data_i(bus_wdata[FRAME_MAX-1:0]),
    .pop_i(start), .data_o(tx_head),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign rx_push = sh_done && !rx_full;
  assign rx_pop  = rd_data && !rx_empty;

  spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .data_i(rx_word),
    .pop_i(rd_data), .data_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spim_clkgen #(.PS_W(8), .RATE_W(8)) u_clk (
    .clk(clk), .rst_n(rst_n), .restart_i(start),
    .prescale_i(presc_q), .rate_i(ctrl0_q[15:8]), .tick_o(tick)
  );

  spim_shifter #(.MAXW(FRAME_MAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
    .tx_word_i(tx_head), .width_m1_i(ctrl0_q[CW-1:0]),
    .cpol_i(ctrl0_q[6]), .cpha_i(ctrl0_q[7]), .loop_i(ctrl1_q[0]),
    .miso_i(miso_i), .running_o(sh_running), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .done_o(sh_done), .rx_word_o(rx_word)
  );

  // Sticky receive flags and the idle-time counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ror_q  <= 1'b0;
      rto_q  <= 1'b0;
      to_cnt <= '0;
    end else begin
      if (sh_done && rx_full) ror_q <= 1'b1;
      else if (clr_ror)       ror_q <= 1'b0;

      if (clr_rto) begin
        rto_q  <= 1'b0;
        to_cnt <= '0;
      end else begin
        if (to_cnt == TO_LIMIT) rto_q <= 1'b1;
        if (rx_push || rx_pop || rx_empty) to_cnt <= '0;
        else if (tick && to_cnt != TO_LIMIT) to_cnt <= to_cnt + 1'b1;
      end
    end
  end

  assign stat.busy         = sh_running || (enable && !tx_empty);
  assign stat.rx_not_full  = !rx_full;
  assign stat.rx_not_empty = !rx_empty;
  assign stat.tx_not_full  = !tx_full;
  assign stat.tx_empty     = tx_empty;

  assign raw.tx_lvl     = (tx_cnt <= LVL_MARK);
  assign raw.rx_lvl     = (rx_cnt >= LVL_MARK);
  assign raw.rx_timeout = rto_q;
  assign raw.rx_overrun = ror_q;
  assign mskd  = raw & imask_q;
  assign irq_o = |mskd;

  always_comb begin
    bus_rdata = '0;
    if (id_hit) begin
      bus_rdata = {24'b0, id_byte(bus_addr[4:2])};
    end else if (word_ok) begin
      case (bus_addr[11:2])
        IDX_CTRL0:  bus_rdata = {16'b0, ctrl0_q};
        IDX_CTRL1:  bus_rdata = {28'b0, ctrl1_q};
        IDX_DATA:   bus_rdata = rx_empty ? '0 : 32'(rx_head);
        IDX_STATUS: bus_rdata = {27'b0, stat};
        IDX_PRESC:  bus_rdata = {24'b0, presc_q};
        IDX_IMASK:  bus_rdata = {28'b0, imask_q};
        IDX_IRAW:   bus_rdata = {28'b0, raw};
        IDX_IMASKD: bus_rdata = {28'b0, mskd};
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R10: a frame landing on a full receive queue raises the overrun flag
  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && rx_full) |=> ror_q);

  // R12: no frame begins while the port is disabled
  assert_no_start_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !sh_running) |=> !sh_running);

  // R11: the timeout flag only rises after the queue held data
  assert_timeout_needs_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rto_q) |-> $past(!rx_empty));

endmodule

// File: tb/spi_fifo_master_bench.sv
`timescale 1ns/1ps
module spi_fifo_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk_o, mosi_o, irq_o;
  logic        miso_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  localparam logic [11:0] A_C0 = 12'h000, A_C1 = 12'h004, A_DAT = 12'h008,
                          A_ST = 12'h00C, A_PS = 12'h010, A_IM = 12'h014,
                          A_RAW = 12'h018, A_MIS = 12'h01C, A_CLR = 12'h020;

  // {width-1, cpol, cpha, prescale, rate, data}
  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {4'd7,  1'b0, 1'b0, 8'd2, 8'd0, 16'h00A5},
    {4'd7,  1'b0, 1'b1, 8'd4, 8'd1, 16'h003C},
    {4'd15, 1'b1, 1'b0, 8'd2, 8'd2, 16'hBEEF},
    {4'd15, 1'b1, 1'b1, 8'd6, 8'd0, 16'h1234},
    {4'd11, 1'b0, 1'b1, 8'd2, 8'd1, 16'hFABC},
    {4'd3,  1'b1, 1'b1, 8'd8, 8'd0, 16'h00F9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(A_ST, s);
      if (!s[4]) break;
    end
  endtask

  task automatic cfg(input logic [3:0] wm1, input logic cpol, input logic cpha,
                     input logic [7:0] ps, input logic [7:0] rate, input logic [3:0] c1);
    wr(A_C1, 32'h0);
    wr(A_PS, {24'b0, ps});
    wr(A_C0, {16'b0, rate, cpha, cpol, 2'b00, wm1});
    wr(A_C1, {28'b0, c1});
  endtask

  task automatic half_period(output int clocks);
    realtime t0;
    @(sclk_o);
    t0 = $realtime;
    @(sclk_o);
    clocks = int'(($realtime - t0) / 20.0);
  endtask

  task automatic phase_probe(input logic cpol, input logic cpha,
                             output int toggles, output logic first_level);
    logic prev;
    cfg(4'd7, cpol, cpha, 8'd4, 8'd1, 4'h3);
    wr(A_DAT, 32'h80);
    for (int k = 0; k < 200 && mosi_o !== 1'b1; k++) @(posedge clk);
    toggles = 0; first_level = 1'bx;
    prev = sclk_o;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      if (sclk_o !== prev) begin
        toggles++;
        if (toggles == 1) first_level = sclk_o;
        prev = sclk_o;
      end
      if (mosi_o === 1'b0) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R12 watchdog: actual=still running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    logic [3:0]  wm1;
    logic        cp, ch, lvl;
    logic [7:0]  ps, rt;
    logic [15:0] dat;
    int          n;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_ST, d);  check("R1 status", d, 32'h0B);
    rd(A_RAW, d); check("R1 raw irq", d, 32'h08);
    check("R1 sclk", {31'b0, sclk_o}, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 readback and identification
    wr(A_C0, 32'h0000A5C7); rd(A_C0, d); check("R2 ctrl0", d, 32'hA5C7);
    wr(A_PS, 32'h37);       rd(A_PS, d); check("R2 prescale", d, 32'h37);
    wr(A_IM, 32'hF);        rd(A_IM, d); check("R2 mask", d, 32'hF);
    wr(A_IM, 32'h0);
    wr(A_C1, 32'h5);        rd(A_C1, d); check("R2 ctrl1", d, 32'h5);
    rd(12'hFE0, d); check("R2 id0", d, 32'h22);
    rd(12'hFE8, d); check("R2 id2", d, 32'h04);
    rd(12'hFF4, d); check("R2 id5", d, 32'hF0);
    rd(12'hFFC, d); check("R2 id7", d, 32'hB1);

    // R5 R6 R7: loopback frames across widths and modes
    for (int i = 0; i < NV; i++) begin
      {wm1, cp, ch, ps, rt, dat} = VEC[i];
      cfg(wm1, cp, ch, ps, rt, 4'h3);
      repeat (2) @(negedge clk);
      check($sformatf("R6 idle level vec%0d", i), {31'b0, sclk_o}, {31'b0, cp});
      wr(A_DAT, {16'b0, dat});
      wait_idle();
      rd(A_DAT, d);
      exp = {16'b0, dat} & ((32'h1 << (wm1 + 1)) - 1);
      check($sformatf("R5 loopback vec%0d", i), d, exp);
    end

    // R4 divider
    cfg(4'd7, 1'b0, 1'b0, 8'd4, 8'd2, 4'h3);
    wr(A_DAT, 32'h55); half_period(n); check("R4 ps4 rate2", n, 6);
    wait_idle(); rd(A_DAT, d);
    cfg(4'd7, 1'b0, 1'b0, 8'd5, 8'd0, 4'h3);
    wr(A_DAT, 32'h55); half_period(n); check("R4 ps5 bit0 ignored", n, 2);
    wait_idle(); rd(A_DAT, d);
    cfg(4'd7, 1'b0, 1'b0, 8'd0, 8'd1, 4'h3);
    wr(A_DAT, 32'h55); half_period(n); check("R4 ps0 acts as 2", n, 2);
    wait_idle(); rd(A_DAT, d);

    // R6 phase: first data change position and first edge direction
    phase_probe(1'b0, 1'b0, n, lvl);
    check("R6 cpha0 change edge", n, 2);
    check("R6 cpol0 first edge rises", {31'b0, lvl}, 32'h1);
    wait_idle(); rd(A_DAT, d);
    phase_probe(1'b1, 1'b1, n, lvl);
    check("R6 cpha1 change edge", n, 3);
    check("R6 cpol1 first edge falls", {31'b0, lvl}, 32'h0);
    wait_idle(); rd(A_DAT, d);

    // R7 external input versus loopback
    miso_i = 1'b1;
    cfg(4'd7, 1'b0, 1'b0, 8'd2, 8'd0, 4'h2);
    wr(A_DAT, 32'h00); wait_idle(); rd(A_DAT, d); check("R7 pin high", d, 32'hFF);
    miso_i = 1'b0;
    wr(A_DAT, 32'hFF); wait_idle(); rd(A_DAT, d); check("R7 pin low", d, 32'h00);
    miso_i = 1'b1;
    wr(A_C1, 32'h3);
    wr(A_DAT, 32'h00); wait_idle(); rd(A_DAT, d); check("R7 loopback ignores pin", d, 32'h00);
    miso_i = 1'b0;

    // R3 R8 R9: fill transmit queue while disabled
    cfg(4'd7, 1'b0, 1'b0, 8'd2, 8'd0, 4'h1);
    for (int k = 1; k <= 5; k++) wr(A_DAT, 32'h11 * k);
    rd(A_RAW, d); check("R9 tx level off at 5", d & 32'h8, 32'h0);
    rd(A_ST, d);  check("R12 idle when disabled", d, 32'h0A);
    for (int k = 6; k <= 9; k++) wr(A_DAT, 32'h11 * k);
    rd(A_ST, d);  check("R8 tx full status", d, 32'h08);
    wr(A_C1, 32'h3);
    wait_idle();
    rd(A_ST, d);  check("R8 rx full status", d, 32'h07);
    wr(A_DAT, 32'hAA);
    wait_idle();
    rd(A_RAW, d); check("R10 overrun raw", d & 32'hD, 32'hD);
    wr(A_IM, 32'h1);
    rd(A_MIS, d); check("R9 masked", d, 32'h1);
    check("R9 irq line", {31'b0, irq_o}, 32'h1);
    wr(A_CLR, 32'h1);
    rd(A_RAW, d); check("R10 overrun cleared", d & 32'h1, 32'h0);
    check("R9 irq low", {31'b0, irq_o}, 32'h0);
    wr(A_IM, 32'h0);
    for (int k = 1; k <= 8; k++) begin
      rd(A_DAT, d); check($sformatf("R3 order word%0d", k), d, 32'h11 * k);
      if (k == 5) begin
        rd(A_RAW, d); check("R9 rx level off at 3", d & 32'h4, 32'h0);
      end
    end
    rd(A_DAT, d); check("R3 empty read", d, 32'h0);

    // R11 timeout
    wr(A_DAT, 32'h5A); wait_idle();
    wr(A_CLR, 32'h2);
    rd(A_RAW, d); check("R11 no early timeout", d & 32'h2, 32'h0);
    repeat (150) @(negedge clk);
    rd(A_RAW, d); check("R11 timeout set", d & 32'h2, 32'h2);
    wr(A_CLR, 32'h2);
    rd(A_RAW, d); check("R11 timeout cleared", d & 32'h2, 32'h0);
    rd(A_DAT, d); check("R11 data kept", d, 32'h5A);

    // R12 disable mid-frame
    cfg(4'd15, 1'b0, 1'b0, 8'd4, 8'd3, 4'h3);
    wr(A_DAT, 32'h1357); wr(A_DAT, 32'h2468);
    repeat (20) @(negedge clk);
    wr(A_C1, 32'h1);
    wait_idle();
    rd(A_ST, d);  check("R12 stop after frame", d, 32'h0E);
    rd(A_DAT, d); check("R12 first frame done", d, 32'h1357);
    wr(A_C1, 32'h3);
    wait_idle();
    rd(A_DAT, d); check("R12 resumed", d, 32'h2468);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule